// File: doc/BRIEF.md
# Input-Capture Period Measurement Timer

This block measures the period of an external digital signal. A 16-bit free-running counter advances once per count-clock tick, where the tick rate is the system clock divided by a selectable power of two. The signal pin passes through a two-flop synchronizer. On each qualifying transition (rising, falling or both, chosen by software), the counter value is copied into a capture register. A capture flag and an overflow flag, each with its own interrupt enable, drive two level interrupt request lines.

Wraps of the counter from FFFFh to 0000h are counted between captures. This extends the 16-bit time base, so the block can report a full period: the overflow count times 65536, plus the current capture, minus the previous capture. The period is presented on a 32-bit output together with a one-cycle valid strobe. Software reaches the block through a four-word register port with combinational reads and single-cycle writes.

A small state machine qualifies the period output. Its states are:
- ST_OFF: edge detection is disabled.
- ST_FIRST: armed, waiting for a first capture that has no predecessor.
- ST_RUN: a previous capture exists.

Its transitions are:
- OFF to FIRST, when a non-zero edge mode is written.
- FIRST to RUN, on a capture.
- RUN to FIRST, on a counter clear.
- Any state to OFF, when the edge mode returns to disabled.

Top module: `icp_timer`

## Requirements
- R1: After reset, the control word at address 0 reads 0x0020 (count clock select = 2, every other field 0). The counter reads 0, and both interrupt lines and the period strobe are low.
- R2: While control bit 0 (count enable) is 1, the counter increments once every 2^S system clocks, where S is control bits 5:4. The divisors are 1, 2, 4 and 8. While bit 0 is 0, the counter holds its value.
- R3: When the counter wraps from FFFFh to 0000h, control bit 3 (overflow flag) is set on that edge. The overflow interrupt line equals that flag AND control bit 2 (overflow interrupt enable).
- R4: Control bits 7:6 select the capture edge: 00 none, 01 rising, 10 falling, 11 both. If the pin change is sampled at clock edge k, the capture register (address 2) takes the counter value held after edge k+1, and it does so at edge k+2.
- R5: Each capture sets control bit 9 (capture flag). The capture interrupt line equals that flag AND control bit 8 (capture interrupt enable).
- R6: A control write of 0 to bit 3 or bit 9 clears that flag. A write of 1 leaves it unchanged. A hardware set in the same cycle wins.
- R7: A control write with bit 1 = 1 zeroes the counter, the prescaler and the overflow count on that edge. Bit 1 always reads 0, and the next capture is treated as a first capture.
- R8: A write to address 1 loads the counter with the written value and restarts the prescaler.
- R9: Address 3 reads the number of counter wraps since the last capture, clear or reset. A capture resets this count.
- R10: The first capture after reset, after a clear, or after leaving mode 00 produces no period strobe. Each later capture raises the period strobe for exactly one cycle, on the same edge that updates the capture register.
- R11: The reported period equals overflow count × 65536 + current capture − previous capture. This is the exact number of count-clock ticks between the two captures.
- R12: When a capture and a wrap fall on the same edge, the captured value is FFFFh. That wrap belongs to the next period, so the overflow count reads 1 afterwards. A capture of 0000h includes the wrap that produced it, so the overflow count reads 0 afterwards.
- R13: Register addresses are 0 control/status, 1 counter, 2 capture, 3 overflow count. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 2 | Register select |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the selected register |
| cap_pin_i | input | 1 | Asynchronous signal to be measured |
| irq_ovf_o | output | 1 | Overflow interrupt request (level) |
| irq_cap_o | output | 1 | Capture interrupt request (level) |
| period_o | output | 32 | Ticks between the last two captures |
| period_vld_o | output | 1 | One-cycle strobe for period_o |

## Verification
Reads are combinational, so a written register value is checked on the falling edge right after the write's rising edge. In /1 mode a counter loaded with L at edge c0 holds L+(c−c0) after edge c.

A pin change driven on the falling edge at cycle x shows up in the capture register, the capture flag and the period strobe after edge x+3. The bench therefore waits exactly three falling edges before sampling them, and one more to see the strobe drop. An overflow flag is due on the edge after the counter holds FFFFh.

Expected captures and periods come from the bench's own cycle count. In /1 mode the period must equal the distance in cycles between the two stimulus changes.

// File: rtl/icp_pkg.sv
package icp_pkg;
    // capture edge modes
    localparam logic [1:0] EDGE_NONE = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;

    // register addresses
    localparam logic [1:0] ADDR_CTRL    = 2'd0;
    localparam logic [1:0] ADDR_COUNT   = 2'd1;
    localparam logic [1:0] ADDR_CAPTURE = 2'd2;
    localparam logic [1:0] ADDR_OVFCNT  = 2'd3;

    // control word bit positions
    localparam int CB_EN    = 0;
    localparam int CB_CLR   = 1;
    localparam int CB_OVIE  = 2;
    localparam int CB_OVF   = 3;
    localparam int CB_SEL   = 4;
    localparam int CB_EDGE  = 6;
    localparam int CB_CAPIE = 8;
    localparam int CB_CAPF  = 9;
    localparam int CTRL_W   = 10;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_FIRST = 2'b01,
        ST_RUN   = 2'b10
    } cap_state_e;
endpackage

// File: rtl/icp_timebase.sv
module icp_timebase #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_last;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    always_comb begin
        pre_last = PRE_W'((32'd1 << clk_sel_i) - 32'd1);
        tick     = en_i && (pre_q == pre_last);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else if (clr_i || load_i) begin
            pre_q <= '0;
        end else if (en_i) begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick && (cnt_q == '1) && !clr_i && !load_i;

    AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni) clr_i |=> (cnt_q == '0)); // R7
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni) (!en_i && !clr_i && !load_i) |=> $stable(cnt_q)); // R2
    AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) wrap_o |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/icp_edge_detect.sv
module icp_edge_detect
    import icp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pin_i,
    input  logic [1:0] mode_i,
    output logic       evt_o
);
    logic [SYNC_STAGES:0] sh_q;
    logic                 lvl;
    logic                 lvl_prev;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
        end
    end

    assign lvl      = sh_q[SYNC_STAGES-1];
    assign lvl_prev = sh_q[SYNC_STAGES];

    always_comb begin
        unique case (mode_i)
            EDGE_NONE: evt_o = 1'b0;
            EDGE_RISE: evt_o = lvl && !lvl_prev;
            EDGE_FALL: evt_o = !lvl && lvl_prev;
            EDGE_BOTH: evt_o = lvl ^ lvl_prev;
            default:   evt_o = 1'b0;
        endcase
    end

    AST_RISE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni) (evt_o && mode_i == EDGE_RISE) |-> lvl); // R4
    AST_FALL_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni) (evt_o && mode_i == EDGE_FALL) |-> !lvl); // R4
endmodule

// File: rtl/icp_capture.sv
module icp_capture
    import icp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int OVF_W = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   evt_i,
    input  logic                   wrap_i,
    input  logic                   clr_i,
    input  logic                   armed_i,
    input  logic [CNT_W-1:0]       cnt_i,
    output logic [CNT_W-1:0]       cap_o,
    output logic [OVF_W-1:0]       ovf_cnt_o,
    output logic [OVF_W+CNT_W-1:0] period_o,
    output logic                   period_vld_o
);
    localparam int PER_W = OVF_W + CNT_W;

    cap_state_e       state_q, state_d;
    logic [CNT_W-1:0] cap_q;
    logic [OVF_W-1:0] ovf_cnt_q;
    logic [PER_W-1:0] period_q;
    logic             vld_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (armed_i) state_d = ST_FIRST;
            ST_FIRST: begin
                if (!armed_i)             state_d = ST_OFF;
                else if (evt_i && !clr_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!armed_i)   state_d = ST_OFF;
                else if (clr_i) state_d = ST_FIRST;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs and data path
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q     <= '0;
            ovf_cnt_q <= '0;
            period_q  <= '0;
            vld_q     <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (evt_i) cap_q <= cnt_i;
            if (clr_i) begin
                ovf_cnt_q <= '0;
            end else if (evt_i) begin
                // a wrap on the capture edge opens the next period
                ovf_cnt_q <= wrap_i ? OVF_W'(1) : '0;
            end else if (wrap_i) begin
                ovf_cnt_q <= ovf_cnt_q + OVF_W'(1);
            end
            if (evt_i && !clr_i && armed_i && state_q == ST_RUN) begin
                period_q <= {ovf_cnt_q, {CNT_W{1'b0}}} + PER_W'(cnt_i) - PER_W'(cap_q);
                vld_q    <= 1'b1;
            end
        end
    end

    assign cap_o        = cap_q;
    assign ovf_cnt_o    = ovf_cnt_q;
    assign period_o     = period_q;
    assign period_vld_o = vld_q;

    AST_CAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni) evt_i |=> (cap_q == $past(cnt_i))); // R4
    AST_OVFCNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni) (evt_i && !wrap_i) |=> (ovf_cnt_q == '0)); // R9
    AST_SAME_EDGE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) (evt_i && wrap_i && !clr_i) |=> (ovf_cnt_q == OVF_W'(1))); // R12
    AST_FIRST_NO_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni) (evt_i && state_q != ST_RUN) |=> !vld_q); // R10
    AST_PERIOD_FROM_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni) vld_q |-> ($past(state_q) == ST_RUN)); // R10
endmodule

// File: rtl/icp_timer.sv
module icp_timer
    import icp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int OVF_W       = 16,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [1:0]             bus_addr_i,
    input  logic                   bus_wr_i,
    input  logic [CNT_W-1:0]       bus_wdata_i,
    output logic [CNT_W-1:0]       bus_rdata_o,
    input  logic                   cap_pin_i,
    output logic                   irq_ovf_o,
    output logic                   irq_cap_o,
    output logic [OVF_W+CNT_W-1:0] period_o,
    output logic                   period_vld_o
);
    localparam int DATA_W = CNT_W;
    localparam logic [SEL_W-1:0] SEL_RESET = SEL_W'(2);

    logic             cnt_en_q, ovf_ie_q, cap_ie_q;
    logic             ovf_flag_q, cap_flag_q, ovf_flag_d, cap_flag_d;
    logic [SEL_W-1:0] clk_sel_q;
    logic [1:0]       edge_sel_q;
    logic             ctrl_wr, clr, load, wrap, cap_evt;
    logic [CNT_W-1:0] cnt, cap_val;
    logic [OVF_W-1:0] ovf_cnt;
    logic [CTRL_W-1:0] ctrl_rd;
    logic             unused_wdata;

    assign ctrl_wr      = bus_wr_i && (bus_addr_i == ADDR_CTRL);
    assign clr          = ctrl_wr && bus_wdata_i[CB_CLR];
    assign load         = bus_wr_i && (bus_addr_i == ADDR_COUNT);
    assign unused_wdata = ^bus_wdata_i[DATA_W-1:CTRL_W];

    always_comb begin
        ovf_flag_d = ovf_flag_q;
        cap_flag_d = cap_flag_q;
        if (ctrl_wr && !bus_wdata_i[CB_OVF])  ovf_flag_d = 1'b0;
        if (ctrl_wr && !bus_wdata_i[CB_CAPF]) cap_flag_d = 1'b0;
        if (wrap)    ovf_flag_d = 1'b1;
        if (cap_evt) cap_flag_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_en_q   <= 1'b0;
            ovf_ie_q   <= 1'b0;
            cap_ie_q   <= 1'b0;
            clk_sel_q  <= SEL_RESET;
            edge_sel_q <= EDGE_NONE;
            ovf_flag_q <= 1'b0;
            cap_flag_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                cnt_en_q   <= bus_wdata_i[CB_EN];
                ovf_ie_q   <= bus_wdata_i[CB_OVIE];
                cap_ie_q   <= bus_wdata_i[CB_CAPIE];
                clk_sel_q  <= bus_wdata_i[CB_SEL +: SEL_W];
                edge_sel_q <= bus_wdata_i[CB_EDGE +: 2];
            end
            ovf_flag_q <= ovf_flag_d;
            cap_flag_q <= cap_flag_d;
        end
    end

    icp_timebase #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_timebase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (cnt_en_q),
        .clk_sel_i  (clk_sel_q),
        .clr_i      (clr),
        .load_i     (load),
        .load_val_i (bus_wdata_i),
        .cnt_o      (cnt),
        .wrap_o     (wrap)
    );

    icp_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (cap_pin_i),
        .mode_i (edge_sel_q),
        .evt_o  (cap_evt)
    );

    icp_capture #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_capture (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .evt_i        (cap_evt),
        .wrap_i       (wrap),
        .clr_i        (clr),
        .armed_i      (edge_sel_q != EDGE_NONE),
        .cnt_i        (cnt),
        .cap_o        (cap_val),
        .ovf_cnt_o    (ovf_cnt),
        .period_o     (period_o),
        .period_vld_o (period_vld_o)
    );

    always_comb begin
        ctrl_rd                     = '0;
        ctrl_rd[CB_EN]              = cnt_en_q;
        ctrl_rd[CB_OVIE]            = ovf_ie_q;
        ctrl_rd[CB_OVF]             = ovf_flag_q;
        ctrl_rd[CB_SEL +: SEL_W]    = clk_sel_q;
        ctrl_rd[CB_EDGE +: 2]       = edge_sel_q;
        ctrl_rd[CB_CAPIE]           = cap_ie_q;
        ctrl_rd[CB_CAPF]            = cap_flag_q;
        case (bus_addr_i)
            ADDR_CTRL:    bus_rdata_o = DATA_W'(ctrl_rd);
            ADDR_COUNT:   bus_rdata_o = cnt;
            ADDR_CAPTURE: bus_rdata_o = cap_val;
            ADDR_OVFCNT:  bus_rdata_o = DATA_W'(ovf_cnt);
            default:      bus_rdata_o = '0;
        endcase
    end

    assign irq_ovf_o = ovf_flag_q && ovf_ie_q;
    assign irq_cap_o = cap_flag_q && cap_ie_q;

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni) wrap |=> ovf_flag_q); // R3
    AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni) cap_evt |=> cap_flag_q); // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni) (!ctrl_wr && !cap_evt) |=> $stable(cap_flag_q)); // R6
endmodule

// File: tb/icp_timer_tb.sv
module icp_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr;
    logic        wr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        pin;
    logic        irq_ovf, irq_cap;
    logic [31:0] period;
    logic        vld;

    int unsigned cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    icp_timer u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cap_pin_i(pin),
        .irq_ovf_o(irq_ovf), .irq_cap_o(irq_cap), .period_o(period), .period_vld_o(vld)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [15:0] ctrl_word(input bit en, input bit clr, input bit ovie,
                                               input bit keep_ovf, input logic [1:0] sel,
                                               input logic [1:0] edgem, input bit capie,
                                               input bit keep_cap);
        return {6'b0, keep_cap, capie, edgem, sel, keep_ovf, ovie, clr, en};
    endfunction

    function automatic logic [15:0] exp_cap(input logic [15:0] l, input int unsigned x,
                                            input int unsigned c0);
        return 16'(int'(l) + int'(x) + 2 - int'(c0));
    endfunction

    function automatic logic [31:0] exp_period(input int unsigned x_now, input int unsigned x_prev);
        return 32'(x_now - x_prev);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2, l;
        int unsigned c0, x, x2, xprev;
        int unsigned seed;
        addr = 2'd0; wr = 1'b0; wdata = '0; pin = 1'b0;
        seed = $urandom(32'h5EED1234);
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); check("R1/R13 ctrl reset", 32'(v), 32'h0020);
        rd(2'd1, v); check("R1 counter reset", 32'(v), 0);
        check("R1 irq_ovf", 32'(irq_ovf), 0);
        check("R1 irq_cap", 32'(irq_cap), 0);
        check("R1 period_vld", 32'(vld), 0);

        // R2 divider rates
        for (int s = 0; s < 4; s++) begin
            bus_wr(2'd0, ctrl_word(1, 0, 0, 1, 2'(s), 2'b00, 0, 1));
            bus_wr(2'd1, 16'h0000);
            tick(40);
            rd(2'd1, v);
            check("R2 divide rate", 32'(v), 32'(40 >> s));
        end
        // R8 load
        bus_wr(2'd0, ctrl_word(1, 0, 0, 1, 2'b00, 2'b00, 0, 1));
        bus_wr(2'd1, 16'h1234);
        rd(2'd1, v); check("R8 load value", 32'(v), 32'h1234);
        tick(6);
        rd(2'd1, v); check("R8 count after load", 32'(v), 32'h123A);
        // R2 enable off
        bus_wr(2'd0, ctrl_word(0, 0, 0, 1, 2'b00, 2'b00, 0, 1));
        rd(2'd1, v); tick(10); rd(2'd1, v2);
        check("R2 hold when disabled", 32'(v2), 32'(v));

        // R3 overflow flag and irq
        bus_wr(2'd0, ctrl_word(1, 0, 1, 1, 2'b00, 2'b00, 0, 1));
        bus_wr(2'd1, 16'hFFFD);
        tick(2);
        rd(2'd0, v); check("R3 no flag before wrap", 32'(v[3]), 0);
        check("R3 no irq before wrap", 32'(irq_ovf), 0);
        tick(1);
        rd(2'd0, v); check("R3 flag at wrap", 32'(v[3]), 1);
        check("R3 irq at wrap", 32'(irq_ovf), 1);
        rd(2'd1, v); check("R3 counter wrapped", 32'(v), 0);
        // R6 write 1 keeps, write 0 clears
        bus_wr(2'd0, ctrl_word(1, 0, 1, 1, 2'b00, 2'b00, 0, 1));
        rd(2'd0, v); check("R6 write one keeps", 32'(v[3]), 1);
        bus_wr(2'd0, ctrl_word(1, 0, 1, 0, 2'b00, 2'b00, 0, 1));
        rd(2'd0, v); check("R6 write zero clears", 32'(v[3]), 0);
        check("R6 irq drops", 32'(irq_ovf), 0);

        // R9 overflow count
        bus_wr(2'd0, ctrl_word(1, 1, 0, 0, 2'b00, 2'b00, 0, 1));
        rd(2'd3, v); check("R9 count after clear", 32'(v), 0);
        bus_wr(2'd1, 16'hFFF0); tick(20);
        rd(2'd3, v); check("R9 one wrap", 32'(v), 1);
        bus_wr(2'd1, 16'hFFF0); tick(20);
        rd(2'd3, v); check("R9 two wraps", 32'(v), 2);
        // R7 clear
        bus_wr(2'd0, ctrl_word(1, 1, 0, 0, 2'b00, 2'b00, 0, 1));
        rd(2'd1, v); check("R7 counter cleared", 32'(v), 0);
        rd(2'd3, v); check("R7 ovf count cleared", 32'(v), 0);
        rd(2'd0, v); check("R7 clear bit reads 0", 32'(v[1]), 0);
        tick(5);
        rd(2'd1, v); check("R7 counts after clear", 32'(v), 5);

        // R4 mode 00 ignores the pin
        pin = 1'b1; tick(6);
        rd(2'd0, v); check("R4 disabled no capture flag", 32'(v[9]), 0);
        pin = 1'b0; tick(6);
        rd(2'd0, v); check("R4 disabled no capture flag fall", 32'(v[9]), 0);

        // R12 capture on wrap edge: FFFF
        bus_wr(2'd0, ctrl_word(1, 1, 0, 0, 2'b00, 2'b01, 1, 0));
        l = 16'hFFF8;
        bus_wr(2'd1, l); c0 = cyc;
        tick(5);
        pin = 1'b1; x = cyc;
        tick(3);
        rd(2'd2, v); check("R4/R12 capture value FFFF", 32'(v), 32'(exp_cap(l, x, c0)));
        rd(2'd3, v); check("R12 wrap counted for next period", 32'(v), 1);
        check("R10 first capture no strobe", 32'(vld), 0);
        rd(2'd0, v); check("R5 capture flag", 32'(v[9]), 1);
        check("R5 capture irq", 32'(irq_cap), 1);
        tick(4); pin = 1'b0; tick(20);
        pin = 1'b1; x2 = cyc;
        tick(3);
        check("R10 strobe on second capture", 32'(vld), 1);
        check("R11 period across wrap", period, exp_period(x2, x));
        tick(1);
        check("R10 strobe lasts one cycle", 32'(vld), 0);
        bus_wr(2'd0, ctrl_word(1, 0, 0, 0, 2'b00, 2'b01, 1, 0));
        check("R6 capture flag cleared", 32'(irq_cap), 0);

        // R12 capture of 0000 includes the wrap
        pin = 1'b0; tick(5);
        bus_wr(2'd0, ctrl_word(1, 1, 0, 0, 2'b00, 2'b01, 1, 0));
        l = 16'hFFF9;
        bus_wr(2'd1, l); c0 = cyc;
        tick(5);
        pin = 1'b1; x = cyc;
        tick(3);
        rd(2'd2, v); check("R12 capture value 0000", 32'(v), 32'(exp_cap(l, x, c0)));
        rd(2'd3, v); check("R12 wrap in this period", 32'(v), 0);

        // random runs: rising, falling, both
        for (int r = 1; r < 4; r++) begin
            bit first;
            bit counts;
            first = 1'b1;
            xprev = 0;
            bus_wr(2'd0, ctrl_word(1, 1, 0, 0, 2'b00, 2'(r), 1, 0));
            l = 16'($urandom);
            bus_wr(2'd1, l); c0 = cyc;
            for (int t = 0; t < 40; t++) begin
                tick(1 + ($urandom % 397));
                pin = ~pin; x = cyc;
                counts = (r == 3) || (r == 1 && pin) || (r == 2 && !pin);
                tick(3);
                if (counts) begin
                    rd(2'd2, v);
                    check("R4 random capture value", 32'(v), 32'(exp_cap(l, x, c0)));
                    check("R10 random strobe", 32'(vld), 32'(!first));
                    if (!first) check("R11 random period", period, exp_period(x, xprev));
                    first = 1'b0;
                    xprev = x;
                end else begin
                    check("R4 ignored edge no strobe", 32'(vld), 0);
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule